// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flags

This block is the arithmetic and logic datapath of a small 8-bit processor. It is purely combinational. An operation code selects the function. The block takes the accumulator, a second 8-bit operand and the five current condition flags, and it returns an 8-bit result, a packed flag byte and a strobe that marks when the result is to be written back into the accumulator. A separate 16-bit adder adds a register pair to HL, and that operation changes only carry.

Each class of operation changes its own subset of the flags. The arithmetic group changes all five flags. The logic group clears carry, and it clears auxiliary carry in every case except a register-form AND. Increment and decrement never touch carry. The rotates and the carry operations touch nothing except carry. Decimal adjust reads the stored auxiliary carry and the stored carry to correct a packed BCD sum. The register file, instruction sequencing and memory traffic are not part of this block. Increment and decrement act on `opnd_i`, and the surrounding logic decides where their result goes.

Top module: `alu8_core`

## Requirements
- R1: In `flags_o`, bit 7 is sign, bit 6 is zero, bit 4 is auxiliary carry, bit 2 is parity (1 for an even count of ones in the result) and bit 0 is carry. Bit 1 is always 1 and bits 3 and 5 are always 0, whatever the input flags. `flags_i` is packed as {sign, zero, aux, parity, carry}, with carry in bit 0.
- R2: Codes 0 (add), 1 (add plus carry), 2 (subtract) and 3 (subtract with borrow) write `acc_i` op `opnd_i` to `result_o` and raise `acc_we_o`. They update all five flags. Carry is the carry out of bit 7, or the borrow for subtraction. Auxiliary carry is the carry or borrow out of bit 3.
- R3: Code 4 (compare) produces the flags and the result of a subtract, but `acc_we_o` stays 0.
- R4: Code 7 (OR) and code 8 (XOR) write the result and clear both carry and auxiliary carry. Sign, zero and parity follow the result.
- R5: Code 5 (register-form AND) clears carry and sets auxiliary carry to the OR of bit 3 of the two operands. Code 6 (immediate-form AND) clears both carry and auxiliary carry. Both codes write the result.
- R6: Code 9 gives `opnd_i`+1 and code 10 gives `opnd_i`-1, modulo 256. Sign, zero, parity and the carry or borrow out of bit 3 are updated. Carry is kept and `acc_we_o` is 0.
- R7: Codes 11 to 14 rotate the accumulator. Code 11 rotates left circularly and code 12 rotates right circularly; the wrapped bit goes both to the far end and into carry. Code 13 rotates left and code 14 rotates right through the 9-bit ring formed by carry and the accumulator. Only carry changes.
- R8: Code 15 writes the bitwise complement of the accumulator and changes no flag.
- R9: Code 16 inverts carry and code 17 sets carry. Neither code changes another flag or writes the accumulator, and `result_o` equals `acc_i`.
- R10: Code 18 (decimal adjust) adds 6 if the low nibble is above 9 or the input auxiliary carry is set. Auxiliary carry becomes the carry out of bit 3 of that step. It then adds 0x60 if that intermediate value carried out of bit 7, has a high nibble above 9, or the input carry is set. Carry becomes 1 exactly in that last case, so it is never cleared once set. Sign, zero and parity follow the result, and the result is written.
- R11: `pair_sum_o` always equals `hl_i` + `pair_i` modulo 65536. Under code 19, carry becomes the overflow out of bit 15, the other flags are kept and `acc_we_o` is 0.
- R12: Codes 20 to 31 keep all flags, drive `result_o` equal to `acc_i` and keep `acc_we_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand (register, memory or immediate) |
| flags_i | input | 5 | Current flags {sign, zero, aux, parity, carry} |
| hl_i | input | 16 | HL pair for the 16-bit add |
| pair_i | input | 16 | Pair added to HL (BC, DE, HL or SP) |
| result_o | output | 8 | 8-bit result |
| flags_o | output | 8 | Packed new flag byte |
| acc_we_o | output | 1 | Result is to be written to the accumulator |
| pair_sum_o | output | 16 | 16-bit pair sum |

## Verification
The checker evaluates its immediate checks each time the combinational outputs settle. It therefore assumes that `op_i` is a known value and that all inputs stay steady between changes. It makes no assumption about which flag bits are set on entry, so any combination of the five input flags is legal. The stimulus changes inputs only on the falling clock edge and reads outputs 2 ns later. It covers every operation code, including the spare ones, with flag patterns that set carry and auxiliary carry independently.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW   = 8;
  localparam int NW   = 4;
  localparam int PW   = 16;
  localparam int OPW  = 5;
  localparam int FLW  = 5;
  localparam int FS   = 7;
  localparam int FZ   = 6;
  localparam int FA   = 4;
  localparam int FP   = 2;
  localparam int FONE = 1;
  localparam int FC   = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBB  = 5'd3,
    OP_CMP  = 5'd4,  OP_ANDR = 5'd5,  OP_ANDI = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_RLC  = 5'd11,
    OP_RRC  = 5'd12, OP_RAL  = 5'd13, OP_RAR  = 5'd14, OP_CMA  = 5'd15,
    OP_CMC  = 5'd16, OP_STC  = 5'd17, OP_DAA  = 5'd18, OP_DAD  = 5'd19
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic a;
    logic p;
    logic c;
  } flags_t;

  // 1 when the byte holds an even number of ones
  function automatic logic even_ones(input logic [DW-1:0] v);
    return ~^v;
  endfunction

  // returns {nibble carry/borrow, v +/- 1}
  function automatic logic [DW:0] step_byte(input logic [DW-1:0] v, input logic down);
    logic [DW-1:0] r;
    logic h;
    r = down ? v - 1'b1 : v + 1'b1;
    h = down ? (v[NW-1:0] == '0) : (&v[NW-1:0]);
    return {h, r};
  endfunction
endpackage

// File: rtl/alu8_nibble_adder.sv
module alu8_nibble_adder #(
  parameter int W  = 8,
  parameter int NW = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hcy_o
);
  logic [W-1:0]  b_eff;
  logic          c0;
  logic [NW:0]   lo;
  logic [W-NW:0] hi;

  // subtraction runs as a + ~b + ~borrow; carries are inverted into borrows
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c0    = sub_i ? ~cin_i : cin_i;
  assign lo    = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c0};
  assign hi    = {1'b0, a_i[W-1:NW]} + {1'b0, b_eff[W-1:NW]} + {{(W-NW){1'b0}}, lo[NW]};
  assign sum_o = {hi[W-NW-1:0], lo[NW-1:0]};
  assign cy_o  = sub_i ? ~hi[W-NW] : hi[W-NW];
  assign hcy_o = sub_i ? ~lo[NW] : lo[NW];
endmodule

// File: rtl/alu8_dec_adjust.sv
module alu8_dec_adjust #(
  parameter int W  = 8,
  parameter int NW = 4
) (
  input  logic [W-1:0] a_i,
  input  logic         cy_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o
);
  logic        lo_fix;
  logic        hi_fix;
  logic [NW:0] lo_ext;
  logic [W:0]  mid;

  assign lo_fix = (a_i[NW-1:0] > NW'(9)) | ac_i;
  assign lo_ext = {1'b0, a_i[NW-1:0]} + (lo_fix ? (NW+1)'(6) : '0);
  assign mid    = {1'b0, a_i} + (lo_fix ? (W+1)'(6) : '0);
  assign hi_fix = mid[W] | (mid[W-1:NW] > (W-NW)'(9)) | cy_i;
  assign res_o  = mid[W-1:0] + (hi_fix ? W'(96) : '0);
  assign cy_o   = hi_fix;
  assign ac_o   = lo_ext[NW];
endmodule

// File: rtl/alu8_pair_add.sv
module alu8_pair_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o
);
  assign {cy_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/alu8_flag_pack.sv
module alu8_flag_pack
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  flags_t       f_i,
  output logic [W-1:0] byte_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == FS) begin : g_s
      assign byte_o[i] = f_i.s;
    end else if (i == FZ) begin : g_z
      assign byte_o[i] = f_i.z;
    end else if (i == FA) begin : g_a
      assign byte_o[i] = f_i.a;
    end else if (i == FP) begin : g_p
      assign byte_o[i] = f_i.p;
    end else if (i == FC) begin : g_c
      assign byte_o[i] = f_i.c;
    end else if (i == FONE) begin : g_one
      assign byte_o[i] = 1'b1;
    end else begin : g_zero
      assign byte_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic [FLW-1:0] flags_i,
  input  logic [PW-1:0]  hl_i,
  input  logic [PW-1:0]  pair_i,
  output logic [DW-1:0]  result_o,
  output logic [DW-1:0]  flags_o,
  output logic           acc_we_o,
  output logic [PW-1:0]  pair_sum_o
);
  alu_op_e       op;
  flags_t        fin;
  flags_t        nf;
  logic [DW-1:0] res;
  logic          we;
  logic          szp_upd;

  logic          main_sub;
  logic          main_cin;
  logic [DW-1:0] main_sum;
  logic          main_cy;
  logic          main_hcy;
  logic [DW:0]   step_v;
  logic [DW-1:0] daa_res;
  logic          daa_cy;
  logic          daa_ac;
  logic          pair_cy;

  assign op  = alu_op_e'(op_i);
  assign fin = flags_t'(flags_i);

  assign main_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign main_cin = ((op == OP_ADC) || (op == OP_SBB)) & fin.c;
  assign step_v   = step_byte(opnd_i, op == OP_DEC);

  alu8_nibble_adder #(.W(DW), .NW(NW)) u_main (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (main_cin),
    .sub_i (main_sub),
    .sum_o (main_sum),
    .cy_o  (main_cy),
    .hcy_o (main_hcy)
  );

  alu8_dec_adjust #(.W(DW), .NW(NW)) u_daa (
    .a_i   (acc_i),
    .cy_i  (fin.c),
    .ac_i  (fin.a),
    .res_o (daa_res),
    .cy_o  (daa_cy),
    .ac_o  (daa_ac)
  );

  alu8_pair_add #(.W(PW)) u_pair (
    .a_i   (hl_i),
    .b_i   (pair_i),
    .sum_o (pair_sum_o),
    .cy_o  (pair_cy)
  );

  always_comb begin
    nf      = fin;
    res     = acc_i;
    we      = 1'b0;
    szp_upd = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        res     = main_sum;
        nf.c    = main_cy;
        nf.a    = main_hcy;
        szp_upd = 1'b1;
        we      = (op != OP_CMP);
      end
      OP_ANDR, OP_ANDI: begin
        res     = acc_i & opnd_i;
        nf.c    = 1'b0;
        nf.a    = (op == OP_ANDR) ? (acc_i[NW-1] | opnd_i[NW-1]) : 1'b0;
        szp_upd = 1'b1;
        we      = 1'b1;
      end
      OP_OR, OP_XOR: begin
        res     = (op == OP_OR) ? (acc_i | opnd_i) : (acc_i ^ opnd_i);
        nf.c    = 1'b0;
        nf.a    = 1'b0;
        szp_upd = 1'b1;
        we      = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res     = step_v[DW-1:0];
        nf.a    = step_v[DW];
        szp_upd = 1'b1;
      end
      OP_RLC: begin
        res  = {acc_i[DW-2:0], acc_i[DW-1]};
        nf.c = acc_i[DW-1];
        we   = 1'b1;
      end
      OP_RRC: begin
        res  = {acc_i[0], acc_i[DW-1:1]};
        nf.c = acc_i[0];
        we   = 1'b1;
      end
      OP_RAL: begin
        res  = {acc_i[DW-2:0], fin.c};
        nf.c = acc_i[DW-1];
        we   = 1'b1;
      end
      OP_RAR: begin
        res  = {fin.c, acc_i[DW-1:1]};
        nf.c = acc_i[0];
        we   = 1'b1;
      end
      OP_CMA: begin
        res = ~acc_i;
        we  = 1'b1;
      end
      OP_CMC: nf.c = ~fin.c;
      OP_STC: nf.c = 1'b1;
      OP_DAA: begin
        res     = daa_res;
        nf.c    = daa_cy;
        nf.a    = daa_ac;
        szp_upd = 1'b1;
        we      = 1'b1;
      end
      OP_DAD: nf.c = pair_cy;
      default: ;
    endcase
    if (szp_upd) begin
      nf.s = res[DW-1];
      nf.z = (res == '0);
      nf.p = even_ones(res);
    end
  end

  alu8_flag_pack #(.W(DW)) u_pack (
    .f_i    (nf),
    .byte_o (flags_o)
  );

  assign result_o = res;
  assign acc_we_o = we;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic [OPW-1:0] op_i,
  input logic [FLW-1:0] flags_i,
  input logic [DW-1:0]  result_o,
  input logic [DW-1:0]  flags_o,
  input logic           acc_we_o
);
  logic keep_szap;
  logic is_arith;
  logic is_rot;

  assign keep_szap = (flags_o[FS] == flags_i[4]) && (flags_o[FZ] == flags_i[3]) &&
                     (flags_o[FA] == flags_i[2]) && (flags_o[FP] == flags_i[1]);
  assign is_arith  = (op_i == OP_ADD) || (op_i == OP_ADC) || (op_i == OP_SUB) || (op_i == OP_SBB);
  assign is_rot    = (op_i == OP_RLC) || (op_i == OP_RRC) || (op_i == OP_RAL) || (op_i == OP_RAR);

  always_comb begin
    if (!$isunknown(op_i)) begin
      AST_ZERO_TRACKS: assert (!is_arith || (flags_o[FZ] == (result_o == '0))); // R2
      AST_CMP_NO_WRITE: assert (!(op_i == OP_CMP) || !acc_we_o); // R3
      AST_LOGIC_CLEARS: assert (!((op_i == OP_OR) || (op_i == OP_XOR) || (op_i == OP_ANDI)) || (!flags_o[FC] && !flags_o[FA])); // R4
      AST_ANDR_CY_CLEAR: assert (!(op_i == OP_ANDR) || !flags_o[FC]); // R5
      AST_STEP_KEEPS_CY: assert (!((op_i == OP_INC) || (op_i == OP_DEC)) || (flags_o[FC] == flags_i[0] && !acc_we_o)); // R6
      AST_ROT_ONLY_CY: assert (!is_rot || keep_szap); // R7
      AST_CMA_FLAGS_KEPT: assert (!(op_i == OP_CMA) || (keep_szap && flags_o[FC] == flags_i[0])); // R8
      AST_DAA_CY_STICKY: assert (!((op_i == OP_DAA) && flags_i[0]) || flags_o[FC]); // R10
      AST_PAIR_NO_WRITE: assert (!(op_i == OP_DAD) || (keep_szap && !acc_we_o)); // R11
      AST_SPARE_INERT: assert (!(op_i > OP_DAD) || (keep_szap && flags_o[FC] == flags_i[0] && !acc_we_o)); // R12
    end
  end
endmodule

bind alu8_core alu8_core_chk i_chk (
  .op_i     (op_i),
  .flags_i  (flags_i),
  .result_o (result_o),
  .flags_o  (flags_o),
  .acc_we_o (acc_we_o)
);

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op_i;
  logic [7:0]  acc_i;
  logic [7:0]  opnd_i;
  logic [4:0]  flags_i;
  logic [15:0] hl_i;
  logic [15:0] pair_i;
  logic [7:0]  result_o;
  logic [7:0]  flags_o;
  logic        acc_we_o;
  logic [15:0] pair_sum_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8_core i_alu8_core (
    .op_i       (op_i),
    .acc_i      (acc_i),
    .opnd_i     (opnd_i),
    .flags_i    (flags_i),
    .hl_i       (hl_i),
    .pair_i     (pair_i),
    .result_o   (result_o),
    .flags_o    (flags_o),
    .acc_we_o   (acc_we_o),
    .pair_sum_o (pair_sum_o)
  );

  function automatic int pick(int j);
    case (j)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'hFF;  7: return 8'h99;
      8: return 8'h66;  9: return 8'h5A; 10: return 8'hA5; 11: return 8'h3C;
      12: return 8'h09; 13: return 8'hF0; 14: return 8'h88; default: return 8'h77;
    endcase
  endfunction

  // input flag patterns {s,z,a,p,c}: none, all, aux only, all but aux
  function automatic int fpat(int k);
    case (k)
      0: return 5'b00000;
      1: return 5'b11111;
      2: return 5'b00100;
      default: return 5'b11011;
    endcase
  endfunction

  function automatic string req_of(int op);
    if (op <= 3) return "R2";
    if (op == 4) return "R3";
    if (op == 5 || op == 6) return "R5";
    if (op == 7 || op == 8) return "R4";
    if (op == 9 || op == 10) return "R6";
    if (op >= 11 && op <= 14) return "R7";
    if (op == 15) return "R8";
    if (op == 16 || op == 17) return "R9";
    if (op == 18) return "R10";
    if (op == 19) return "R11";
    return "R12";
  endfunction

  // expected {acc_we, flag byte, result}
  function automatic logic [16:0] model(int op, int a, int b, int fi, int pc);
    int cy, ac, s, z, p, r, t, c, n, lf, hf, we;
    bit szp;
    cy = fi & 1; p = (fi >> 1) & 1; ac = (fi >> 2) & 1; z = (fi >> 3) & 1; s = (fi >> 4) & 1;
    r = a; we = 0; szp = 0;
    case (op)
      0, 1: begin
        c = (op == 1) ? cy : 0; t = a + b + c;
        r = t & 255; cy = (t > 255); ac = (((a & 15) + (b & 15) + c) > 15); szp = 1; we = 1;
      end
      2, 3, 4: begin
        c = (op == 3) ? cy : 0; t = a - b - c;
        r = t & 255; cy = (t < 0); ac = (((a & 15) - (b & 15) - c) < 0); szp = 1; we = (op != 4);
      end
      5: begin r = a & b; cy = 0; ac = ((a | b) >> 3) & 1; szp = 1; we = 1; end
      6: begin r = a & b; cy = 0; ac = 0; szp = 1; we = 1; end
      7: begin r = a | b; cy = 0; ac = 0; szp = 1; we = 1; end
      8: begin r = a ^ b; cy = 0; ac = 0; szp = 1; we = 1; end
      9: begin r = (b + 1) & 255; ac = ((b & 15) == 15); szp = 1; end
      10: begin r = (b + 255) & 255; ac = ((b & 15) == 0); szp = 1; end
      11: begin r = ((a << 1) | (a >> 7)) & 255; cy = a >> 7; we = 1; end
      12: begin r = (a >> 1) | ((a & 1) << 7); cy = a & 1; we = 1; end
      13: begin r = ((a << 1) | cy) & 255; cy = a >> 7; we = 1; end
      14: begin r = (a >> 1) | (cy << 7); cy = a & 1; we = 1; end
      15: begin r = (~a) & 255; we = 1; end
      16: cy = 1 - cy;
      17: cy = 1;
      18: begin
        lf = ((a & 15) > 9) || (ac == 1);
        t  = a + (lf ? 6 : 0);
        ac = lf && (((a & 15) + 6) > 15);
        hf = (t > 255) || (((t >> 4) & 15) > 9) || (cy == 1);
        r  = ((t & 255) + (hf ? 96 : 0)) & 255;
        cy = hf; szp = 1; we = 1;
      end
      19: cy = pc;
      default: ;
    endcase
    if (szp) begin
      n = 0;
      for (int i = 0; i < 8; i++) n += (r >> i) & 1;
      s = (r >> 7) & 1; z = (r == 0); p = ((n % 2) == 0);
    end
    return {we[0], s[0], z[0], 1'b0, ac[0], 1'b0, p[0], 1'b1, cy[0], r[7:0]};
  endfunction

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d acc=%h opnd=%h fl=%b got %h expected %h",
               req, op_i, acc_i, opnd_i, flags_i, act, exp);
    end
  endtask

  task automatic run(int op, int a, int b, int fi);
    @(negedge clk);
    op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = fi[4:0];
    #2;
    check(req_of(op), {acc_we_o, flags_o, result_o}, model(op, a, b, fi, 0));
  endtask

  task automatic run_pair(int hl, int pr, int fi);
    int sum;
    sum = hl + pr;
    @(negedge clk);
    op_i = 5'd19; acc_i = 8'h42; opnd_i = 8'h17; flags_i = fi[4:0];
    hl_i = hl[15:0]; pair_i = pr[15:0];
    #2;
    check("R11", {acc_we_o, flags_o, result_o}, model(19, 8'h42, 8'h17, fi, (sum > 65535) ? 1 : 0));
    checks++;
    if (pair_sum_o !== sum[15:0]) begin
      errors++;
      $display("FAIL R11: pair sum got %h expected %h", pair_sum_o, sum[15:0]);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    op_i = 5'd31; acc_i = 8'h5A; opnd_i = 8'h00; flags_i = 5'b11111;
    hl_i = 16'h0000; pair_i = 16'h0000;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 R12: idle code leaves flags packed with fixed bits, no write
    check("R1 R12", {acc_we_o, flags_o, result_o}, {1'b0, 8'hD7, 8'h5A});
    rst = 1'b0;

    // R2 R3: arithmetic and compare sweep
    for (int o = 0; o < 5; o++)
      for (int k = 0; k < 2; k++)
        for (int a = 0; a < 256; a++)
          for (int j = 0; j < 16; j++)
            run(o, a, pick(j), fpat(k));

    // R4 R5: logic group
    for (int o = 5; o < 9; o++)
      for (int k = 0; k < 2; k++)
        for (int a = 0; a < 256; a++)
          for (int j = 0; j < 16; j++)
            run(o, a, pick(j), fpat(k));

    // R6: increment and decrement over every operand
    for (int o = 9; o < 11; o++)
      for (int k = 0; k < 4; k++)
        for (int b = 0; b < 256; b++)
          run(o, 8'h3C, b, fpat(k));

    // R7 R8 R9: rotates, complement and carry operations
    for (int o = 11; o < 18; o++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++)
          run(o, a, 8'hC3, fpat(k));

    // R10: decimal adjust with every carry/aux combination
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 256; a++)
        run(18, a, 8'h00, fpat(k));

    // R12: spare codes
    for (int o = 20; o < 32; o++)
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < 4; j++)
          run(o, pick(j * 4 + 2), pick(j), fpat(k));

    // R11: pair add, boundaries then a spread
    run_pair(16'hFFFF, 16'h0001, 0);
    run_pair(16'h8000, 16'h8000, 31);
    run_pair(16'hFFFF, 16'h0000, 27);
    run_pair(16'h7FFF, 16'h7FFF, 4);
    for (int i = 0; i < 1024; i++)
      run_pair((i * 40503) & 65535, (i * 7919 + 12345) & 65535, i & 31);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule